// File: doc/BRIEF.md
# I2C Byte-Register Target with Shared Auto-Incrementing Pointer

This block lets an I2C host read and write a small bank of byte-wide registers. It watches SCL and SDA through synchronizers clocked by the system clock. It answers to one 7-bit device address, and it pulls SDA low through an open-drain enable. The register storage sits outside the block and is reached through a simple port: address, write data, a one-cycle write strobe and combinational read data.

A single 8-bit pointer serves both directions. In a write transfer, the first byte after the device address sets the pointer. Each following byte is stored at the pointer, and the pointer then steps forward. A read that begins straight after START continues from wherever the pointer was left. This is one past the last register touched, and it holds across STOP conditions. A random read writes the pointer, issues a repeated START, and then reads. The pointer returns to 00h after the highest implemented index, and also after FFh.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released (`sda_pull_low`=0), `reg_wr_en` is 0 and the pointer (`reg_addr`) is 00h.
- R2: The block ACKs (drives SDA low during the ninth clock) an address byte whose upper 7 bits equal `DEV_ADDR`. For any other address it leaves SDA released until the next START.
- R3: In a write transfer (bit 0 of the address byte = 0), the first byte after the address loads the pointer and causes no write strobe.
- R4: Each later byte of a write transfer produces one `reg_wr_en` pulse of exactly one system clock. The pulse carries the byte on `reg_wdata` and the current pointer on `reg_addr`. The pointer then advances by one. The block ACKs every such byte.
- R5: An advance from the index `TOP_INDEX`, or from FFh, gives 00h. This holds for reads and for writes.
- R6: A read transfer (bit 0 of the address byte = 1) returns the register at the pointer, MSB first. The pointer advances once after each byte has been sent. Its value is kept across STOP, so a read with no address phase resumes where the last access ended.
- R7: A repeated START after the pointer byte, followed by a read address, returns data starting at the newly written pointer.
- R8: If the host ACKs a read byte, the next register's byte follows. If the host NACKs, SDA is released and stays released until the next START.
- R9: For a pointer above `TOP_INDEX`, reads return 00h and writes give no strobe. The byte is still ACKed and the pointer still advances.
- R10: A START or STOP abandons any partly received byte. Nothing is written, and the pointer keeps its value.
- R11: `sda_pull_low` changes only while the synchronized SCL is low.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Register pointer / access address |
| reg_wdata | output | 8 | Write data |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
Several properties are checked on every cycle:
- a write strobe lasts exactly one cycle and never reaches an index above `TOP_INDEX`;
- the pointer stays unchanged unless a load or advance is issued;
- an advance from `TOP_INDEX` lands on 00h;
- SDA changes only while SCL is low;
- an idle bus logic never pulls SDA.

The following behaviours need whole transfers and are shown only by the bench scenarios:
- the data values that arrive in the register file;
- the bytes read back MSB first;
- the pointer resuming after STOP and wrapping from FFh;
- the effect of a repeated START;
- ignored out-of-range writes;
- transfers aborted partway through a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prev;

  assign raw = {sda_in, scl_in};

  // one synchronizer chain per bus line; idle bus is high
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = lvl[0] & ~prev[0];
  assign scl_fall  = ~lvl[0] & prev[0];
  assign bus_start = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign bus_stop  = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/i2c_reg_pointer.sv
module i2c_reg_pointer #(
  parameter int PTR_W     = 8,
  parameter int TOP_INDEX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(TOP_INDEX);
  localparam logic [PTR_W-1:0] PTR_MAX = '1;

  logic [PTR_W-1:0] ptr_n;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | inc;
    ptr_n  = ptr;
    if (load)
      ptr_n = load_val;
    else if (inc)
      ptr_n = (ptr == TOP_IDX || ptr == PTR_MAX) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_n;
  end
endmodule

// File: rtl/i2c_tgt_protocol.sv
module i2c_tgt_protocol
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h3A,
  parameter int         PTR_W     = 8,
  parameter int         TOP_INDEX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       rdata_ext,
  output logic             sda_pull_low,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_load_val,
  output logic             ptr_inc,
  output logic             wr_en,
  output logic [7:0]       wdata,
  output tgt_state_e       state
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(TOP_INDEX);

  tgt_state_e       st_n;
  logic [3:0]       bitcnt, bitcnt_n;
  logic [7:0]       shreg, shreg_n;
  logic             rw, rw_n;
  logic             first, first_n;
  logic             host_ack, host_ack_n;
  logic             drv_n;
  logic             ld_n, inc_n, we_n;
  logic [PTR_W-1:0] ldval_n;
  logic [7:0]       wdata_n;
  logic [7:0]       rd_eff;
  logic [7:0]       rx_byte;
  logic             in_range;

  assign in_range = (ptr <= TOP_IDX);
  assign rd_eff   = in_range ? rdata_ext : 8'h00;
  assign rx_byte  = {shreg[6:0], sda_lvl};

  always_comb begin
    st_n       = state;
    bitcnt_n   = bitcnt;
    shreg_n    = shreg;
    rw_n       = rw;
    first_n    = first;
    host_ack_n = host_ack;
    drv_n      = sda_pull_low;
    ld_n       = 1'b0;
    ldval_n    = ptr_load_val;
    inc_n      = 1'b0;
    we_n       = 1'b0;
    wdata_n    = wdata;
    if (bus_start) begin
      st_n     = ST_ADDR;
      bitcnt_n = '0;
      drv_n    = 1'b0;
    end else if (bus_stop) begin
      st_n  = ST_IDLE;
      drv_n = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg_n  = rx_byte;
            bitcnt_n = bitcnt + 1'b1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            if (shreg[7:1] == DEV_ADDR) begin
              drv_n = 1'b1;
              rw_n  = shreg[0];
              st_n  = ST_ADDR_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_n = '0;
            if (rw) begin
              shreg_n = rd_eff;
              drv_n   = ~rd_eff[7];
              st_n    = ST_TX;
            end else begin
              drv_n   = 1'b0;
              first_n = 1'b1;
              st_n    = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg_n  = rx_byte;
            bitcnt_n = bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              if (first) begin
                ld_n    = 1'b1;
                ldval_n = PTR_W'(rx_byte);
              end else begin
                inc_n   = 1'b1;
                we_n    = in_range;
                wdata_n = rx_byte;
              end
            end
          end
          if (scl_fall && bitcnt == 4'd8) begin
            drv_n = 1'b1;
            st_n  = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            drv_n    = 1'b0;
            first_n  = 1'b0;
            bitcnt_n = '0;
            st_n     = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise && bitcnt < 4'd8)
            bitcnt_n = bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drv_n = 1'b0;
              inc_n = 1'b1;
              st_n  = ST_TX_ACK;
            end else if (bitcnt != 4'd0) begin
              shreg_n = {shreg[6:0], 1'b0};
              drv_n   = ~shreg[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise)
            host_ack_n = ~sda_lvl;
          if (scl_fall) begin
            if (host_ack) begin
              bitcnt_n = '0;
              shreg_n  = rd_eff;
              drv_n    = ~rd_eff[7];
              st_n     = ST_TX;
            end else begin
              drv_n = 1'b0;
              st_n  = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      rw           <= 1'b0;
      first        <= 1'b0;
      host_ack     <= 1'b0;
      sda_pull_low <= 1'b0;
      ptr_load     <= 1'b0;
      ptr_load_val <= '0;
      ptr_inc      <= 1'b0;
      wr_en        <= 1'b0;
      wdata        <= '0;
    end else begin
      state        <= st_n;
      bitcnt       <= bitcnt_n;
      shreg        <= shreg_n;
      rw           <= rw_n;
      first        <= first_n;
      host_ack     <= host_ack_n;
      sda_pull_low <= drv_n;
      ptr_load     <= ld_n;
      ptr_load_val <= ldval_n;
      ptr_inc      <= inc_n;
      wr_en        <= we_n;
      wdata        <= wdata_n;
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         TOP_INDEX   = 15,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_low,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr_en,
  input  logic [7:0] reg_rdata
);
  localparam int PTR_W = 8;

  logic             rst_meta, rst_sync_n;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic             ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_load_val;
  tgt_state_e       state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_tgt_protocol #(
    .DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W), .TOP_INDEX(TOP_INDEX)
  ) u_proto (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .bus_start(bus_start), .bus_stop(bus_stop),
    .ptr(reg_addr), .rdata_ext(reg_rdata), .sda_pull_low(sda_pull_low),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
    .wr_en(reg_wr_en), .wdata(reg_wdata), .state(state)
  );

  i2c_reg_pointer #(.PTR_W(PTR_W), .TOP_INDEX(TOP_INDEX)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(reg_addr)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int TOP_INDEX = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_pull_low,
  input logic       reg_wr_en,
  input logic [7:0] reg_addr,
  input logic       ptr_inc,
  input logic       ptr_load,
  input tgt_state_e state
);
  localparam logic [7:0] TOP_IDX = 8'(TOP_INDEX);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_strobe_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_addr <= TOP_IDX));

  p_wrap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && reg_addr == TOP_IDX) |=> (reg_addr == 8'h00));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_load) |=> $stable(reg_addr));

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !scl_lvl);

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_low);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.TOP_INDEX(TOP_INDEX)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_lvl(scl_lvl), .sda_pull_low(sda_pull_low),
  .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .ptr_inc(ptr_inc),
  .ptr_load(ptr_load), .state(state)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, reg_wr_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [16];
  int errors = 0, checks = 0;
  int we_count = 0, drive_cnt = 0, r11_viol = 0;
  logic prev_drv = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;

  i2c_reg_target #(.DEV_ADDR(DEV), .TOP_INDEX(15)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr_en(reg_wr_en), .reg_rdata(reg_rdata)
  );

  // external register file model; out-of-range reads return a non-zero filler
  always_comb reg_rdata = (reg_addr < 8'd16) ? mem[reg_addr[3:0]] : 8'hEE;

  always @(posedge clk) begin
    if (reg_wr_en) begin
      we_count <= we_count + 1;
      if (reg_addr < 8'd16) mem[reg_addr[3:0]] <= reg_wdata;
    end
    if (sda_pull_low) drive_cnt <= drive_cnt + 1;
    if (rst_n && sda_pull_low != prev_drv && scl_m) r11_viol <= r11_viol + 1;
    prev_drv <= sda_pull_low;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq; wq;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; b = sda_line; wq; scl_m = 1'b0; wq;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack_it);
  endtask

  task automatic t_reset;
    chk("R1 sda released", int'(sda_pull_low), 0);
    chk("R1 no strobe", int'(reg_wr_en), 0);
    chk("R1 pointer", int'(reg_addr), 0);
  endtask

  task automatic t_burst_write;
    logic a; int w0;
    w0 = we_count;
    bus_start;
    put_byte({DEV, 1'b0}, a); chk("R2 addr ack", int'(a), 1);
    put_byte(8'h0E, a);       chk("R3 ptr byte ack", int'(a), 1);
    chk("R3 no strobe for ptr", we_count - w0, 0);
    chk("R3 ptr loaded", int'(reg_addr), 8'h0E);
    put_byte(8'hA1, a);       chk("R4 data ack", int'(a), 1);
    put_byte(8'hA2, a);
    put_byte(8'hA3, a);
    bus_stop;
    chk("R4 strobes", we_count - w0, 3);
    chk("R4 mem 0E", int'(mem[14]), 8'hA1);
    chk("R4 mem 0F", int'(mem[15]), 8'hA2);
    chk("R5 write wrap mem 00", int'(mem[0]), 8'hA3);
    chk("R5 ptr after wrap", int'(reg_addr), 8'h01);
  endtask

  task automatic t_current_read;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b1}, a); chk("R6 read addr ack", int'(a), 1);
    get_byte(1'b1, d);        chk("R6 resume after stop", int'(d), 8'h41);
    get_byte(1'b0, d);        chk("R8 ack gives next byte", int'(d), 8'h42);
    chk("R8 released after nack", int'(sda_pull_low), 0);
    drive_cnt = 0;
    put_bit(1'b0); put_bit(1'b1);
    chk("R8 stays released", drive_cnt, 0);
    bus_stop;
    chk("R6 ptr after read", int'(reg_addr), 8'h03);
  endtask

  task automatic t_random_read;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h0F, a);
    bus_start;
    put_byte({DEV, 1'b1}, a); chk("R7 sr addr ack", int'(a), 1);
    get_byte(1'b1, d);        chk("R7 random read", int'(d), 8'hA2);
    get_byte(1'b1, d);        chk("R5 read wrap", int'(d), 8'hA3);
    get_byte(1'b0, d);        chk("R7 third byte", int'(d), 8'h41);
    bus_stop;
    chk("R7 ptr", int'(reg_addr), 8'h02);
  endtask

  task automatic t_mismatch;
    logic a; int w0;
    w0 = we_count;
    bus_start;
    drive_cnt = 0;
    put_byte(8'h52, a);       chk("R2 no ack on mismatch", int'(a), 0);
    put_byte(8'h03, a);
    put_byte(8'h77, a);
    chk("R2 sda never pulled", drive_cnt, 0);
    bus_stop;
    chk("R2 no write", we_count - w0, 0);
    chk("R2 ptr kept", int'(reg_addr), 8'h02);
  endtask

  task automatic t_out_of_range;
    logic a; logic [7:0] d; int w0;
    w0 = we_count;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h20, a);
    put_byte(8'h55, a);       chk("R9 oor byte acked", int'(a), 1);
    bus_stop;
    chk("R9 no strobe", we_count - w0, 0);
    chk("R9 ptr advanced", int'(reg_addr), 8'h21);
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h20, a);
    bus_start;
    put_byte({DEV, 1'b1}, a);
    get_byte(1'b0, d);        chk("R9 reads zero", int'(d), 8'h00);
    bus_stop;
  endtask

  task automatic t_ff_wrap;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'hFF, a);
    bus_stop;
    bus_start;
    put_byte({DEV, 1'b1}, a);
    get_byte(1'b0, d);        chk("R9 read at FF", int'(d), 8'h00);
    bus_stop;
    chk("R5 FF wraps to 00", int'(reg_addr), 8'h00);
  endtask

  task automatic t_abort;
    logic a; logic [7:0] d; int w0;
    w0 = we_count;
    bus_start;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop;
    chk("R10 released after stop abort", int'(sda_pull_low), 0);
    chk("R10 ptr kept", int'(reg_addr), 8'h00);
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h05, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start;
    put_byte({DEV, 1'b1}, a); chk("R10 addr after abort", int'(a), 1);
    get_byte(1'b0, d);        chk("R10 partial byte not written", int'(d), 8'h45);
    bus_stop;
    chk("R10 no strobe", we_count - w0, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h40 + 8'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_burst_write;
    t_current_read;
    t_random_read;
    t_mismatch;
    t_out_of_range;
    t_ff_wrap;
    t_abort;
    chk("R11 sda changes only with scl low", r11_viol, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule